// File: doc/BRIEF.md
# AC Power-Loss Recovery and Power-Button Controller

This block drives the active-low power-button line that asks an external chipset to turn the main power supply on. Three sources can pull the line low. The first is a physical button, which is gated by an enable. The second is a keyboard-generated button request, which also has its own enable. The third is a one-shot recovery pulse that is issued when the standby domain comes out of reset after AC power returns. Whether the recovery pulse fires depends on a two-bit policy field. The policy can leave the supply off, turn it on, or bring back the supply state that was saved before the outage.

The block also drives the supply-on output as the inverse of the sleep-request input. A status bit records the supply-on level. The bit is sampled on every timebase tick while the system runs, and it freezes when the power-fail input rises, so that software can later read the state the supply had when the failure hit. The status bit sits in the always-on (battery) domain. Only its own reset clears it. The standby reset, whose release triggers recovery, does not clear it.

All timing comes from a single-cycle `tick` strobe. The pulse length is set in milliseconds and converted to ticks. Elaboration fails if that length reaches the button-override time of 4 s. The block has no streaming data, so every pin is plain control or status.

Top module: `pwr_recovery_ctrl`

## Requirements
- R1: `supply_on` equals the inverse of `slp_req` in every cycle.
- R2: While `btn_en` is 1 and `btn_in_n` is 0, `btn_out_n` is 0. When `btn_en` is 0, `btn_in_n` has no effect on `btn_out_n`.
- R3: While `kbd_en` is 1 and `kbd_req_n` is 0, `btn_out_n` is 0. When `kbd_en` is 0, `kbd_req_n` has no effect on `btn_out_n`.
- R4: The recovery pulse drives `btn_out_n` low starting in the first cycle after the clock edge that sees `rst_n` high. It ends on the clock edge that samples its PULSE_TICKS-th `tick`, where PULSE_TICKS = TICK_HZ*PULSE_MS/1000. Elaboration rejects a PULSE_TICKS of zero or one that reaches 4*TICK_HZ.
- R5: Policy 2'b00 (stay off) never produces a recovery pulse. Policy 2'b11 (turn on) always produces one.
- R6: Policy 2'b01 or 2'b10 (restore previous state) produces a recovery pulse exactly when `prev_on` is 1 at the reset-release edge.
- R7: At most one recovery pulse is produced per release of `rst_n`.
- R8: While `rst_n` and `bat_rst_n` are high and `pwr_fail` is 0, `prev_on` takes the value of `supply_on` on each clock edge that samples `tick`=1. While `pwr_fail` is 1, `prev_on` holds its value.
- R9: `prev_on` is cleared to 0 only by `bat_rst_n`. Asserting `rst_n` leaves it unchanged.
- R10: While `rst_n` is low, no recovery pulse is active. With both live requests inactive, `btn_out_n` is then 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| rst_n | input | 1 | Standby-domain reset, active low; its release starts recovery |
| bat_rst_n | input | 1 | Battery-domain reset, active low; clears the saved state |
| tick | input | 1 | Single-cycle timebase strobe at TICK_HZ |
| policy | input | 2 | After-power-loss policy: 00 off, 11 on, 01/10 restore previous |
| pwr_fail | input | 1 | High while an AC failure is detected; freezes the saved state |
| slp_req | input | 1 | Sleep request from chipset, high means supply off |
| btn_in_n | input | 1 | Physical power button, active low |
| btn_en | input | 1 | Enables the physical button path |
| kbd_req_n | input | 1 | Keyboard-generated button request, active low |
| kbd_en | input | 1 | Enables the keyboard request path |
| btn_out_n | output | 1 | Power-button request to chipset, active low |
| supply_on | output | 1 | Supply-on control, inverse of slp_req |
| prev_on | output | 1 | Saved supply state, readable by software |

## Verification
If the saved-state bit is wrong, it shows on `prev_on` at the first tick where it should have changed. It also shows one cycle after the next reset release, because the recovery pulse appears or stays missing on `btn_out_n`. If the pulse counter is wrong, `btn_out_n` rises too early or too late, and the error is off by at least one tick from PULSE_TICKS. If the one-shot arming is wrong, a second low stretch appears later with no live request behind it. The live button paths are combinational, so a bad gate shows on `btn_out_n` in the same cycle.

// File: rtl/prc_pkg.sv
package prc_pkg;

  typedef enum logic [1:0] {
    POL_STAY_OFF  = 2'b00,
    POL_RESTORE_A = 2'b01,
    POL_RESTORE_B = 2'b10,
    POL_TURN_ON   = 2'b11
  } recov_policy_e;

  // Resolve the after-power-loss policy against the saved supply state.
  function automatic logic resolve_on(input logic [1:0] pol, input logic saved);
    case (pol)
      POL_STAY_OFF:  resolve_on = 1'b0;
      POL_TURN_ON:   resolve_on = 1'b1;
      default:       resolve_on = saved;
    endcase
  endfunction

endpackage

// File: rtl/prc_state_latch.sv
module prc_state_latch (
  input  logic clk,
  input  logic bat_rst_n,
  input  logic run,
  input  logic tick,
  input  logic freeze,
  input  logic supply_on,
  output logic prev_on
);

  logic sample_en;
  assign sample_en = run & tick & ~freeze;

  always_ff @(posedge clk or negedge bat_rst_n) begin
    if (!bat_rst_n)     prev_on <= 1'b0;
    else if (sample_en) prev_on <= supply_on;
  end

  // R8: once the failure flag is seen, the saved state must not move
  p_hold_on_fail_r8: assert property (@(posedge clk) disable iff (!bat_rst_n)
    $past(freeze) |-> $stable(prev_on))
    else $error("saved state changed during power failure");

endmodule

// File: rtl/prc_recovery_pulse.sv
module prc_recovery_pulse
  import prc_pkg::*;
#(
  parameter int PULSE_TICKS = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] policy,
  input  logic       saved_on,
  output logic       pulse
);

  localparam int CNT_W = (PULSE_TICKS > 1) ? $clog2(PULSE_TICKS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_TICKS - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b1;
      pulse <= 1'b0;
      cnt   <= '0;
    end else if (armed) begin
      armed <= 1'b0;
      pulse <= resolve_on(policy, saved_on);
      cnt   <= '0;
    end else if (pulse && tick) begin
      if (cnt == LAST) pulse <= 1'b0;
      else             cnt   <= cnt + 1'b1;
    end
  end

  // R7: the pulse may only start on the edge that consumes the arm flag
  p_single_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> $past(armed))
    else $error("recovery pulse restarted without a reset release");

  // R4: the pulse ends only on a sampled tick
  p_end_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse) |-> $past(tick))
    else $error("recovery pulse ended without a tick");

  // R5: the stay-off policy never launches a pulse
  p_off_no_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse) |-> ($past(policy) != POL_STAY_OFF))
    else $error("recovery pulse under stay-off policy");

  // R4: counter never passes the configured length while active
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> (cnt <= LAST))
    else $error("pulse counter out of range");

endmodule

// File: rtl/prc_btn_merge.sv
module prc_btn_merge #(
  parameter int N_SRC = 3
) (
  input  logic [N_SRC-1:0] req_n,
  input  logic [N_SRC-1:0] req_en,
  output logic             btn_out_n
);

  logic [N_SRC-1:0] active;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign active[i] = req_en[i] & ~req_n[i];
  end

  assign btn_out_n = ~(|active);

endmodule

// File: rtl/pwr_recovery_ctrl.sv
module pwr_recovery_ctrl #(
  parameter int TICK_HZ    = 1024,
  parameter int PULSE_MS   = 500,
  parameter int OVERRIDE_S = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bat_rst_n,
  input  logic       tick,
  input  logic [1:0] policy,
  input  logic       pwr_fail,
  input  logic       slp_req,
  input  logic       btn_in_n,
  input  logic       btn_en,
  input  logic       kbd_req_n,
  input  logic       kbd_en,
  output logic       btn_out_n,
  output logic       supply_on,
  output logic       prev_on
);

  localparam int PULSE_TICKS = (TICK_HZ * PULSE_MS) / 1000;
  localparam int OVR_TICKS   = TICK_HZ * OVERRIDE_S;

  if (PULSE_TICKS < 1 || PULSE_TICKS >= OVR_TICKS) begin : g_bad_len
    $error("recovery pulse length must be nonzero and shorter than the override time");
  end

  logic rec_pulse;

  assign supply_on = ~slp_req;

  prc_state_latch u_latch (
    .clk       (clk),
    .bat_rst_n (bat_rst_n),
    .run       (rst_n),
    .tick      (tick),
    .freeze    (pwr_fail),
    .supply_on (supply_on),
    .prev_on   (prev_on)
  );

  prc_recovery_pulse #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .policy   (policy),
    .saved_on (prev_on),
    .pulse    (rec_pulse)
  );

  prc_btn_merge #(.N_SRC(3)) u_merge (
    .req_n     ({~rec_pulse, kbd_req_n, btn_in_n}),
    .req_en    ({1'b1, kbd_en, btn_en}),
    .btn_out_n (btn_out_n)
  );

  // R10: no recovery request can be pending during standby reset
  p_quiet_in_reset_r10: assert property (@(posedge clk)
    (!rst_n && btn_in_n && kbd_req_n) |-> btn_out_n)
    else $error("button output low during reset without a live request");

endmodule

// File: tb/pwr_recovery_ctrl_tb.sv
module pwr_recovery_ctrl_tb;

  localparam int TICK_HZ = 16;
  localparam int PULSE_MS = 500;
  localparam int NT = (TICK_HZ * PULSE_MS) / 1000;

  logic clk = 1'b0;
  logic rst_n, bat_rst_n, tick, pwr_fail, slp_req;
  logic btn_in_n, btn_en, kbd_req_n, kbd_en;
  logic [1:0] policy;
  logic btn_out_n, supply_on, prev_on;

  int n_run = 0;
  int n_fail = 0;

  // reference model state
  logic m_prev, m_armed;
  int   m_left;

  always #4 clk = ~clk;

  pwr_recovery_ctrl #(.TICK_HZ(TICK_HZ), .PULSE_MS(PULSE_MS)) u_dut (
    .clk(clk), .rst_n(rst_n), .bat_rst_n(bat_rst_n), .tick(tick),
    .policy(policy), .pwr_fail(pwr_fail), .slp_req(slp_req),
    .btn_in_n(btn_in_n), .btn_en(btn_en), .kbd_req_n(kbd_req_n),
    .kbd_en(kbd_en), .btn_out_n(btn_out_n), .supply_on(supply_on),
    .prev_on(prev_on)
  );

  function automatic logic want_on(input logic [1:0] p, input logic s);
    if (p == 2'b00) return 1'b0;
    if (p == 2'b11) return 1'b1;
    return s;
  endfunction

  function automatic logic exp_btn();
    logic low;
    low = (btn_en & ~btn_in_n) | (kbd_en & ~kbd_req_n) | (m_left > 0);
    return ~low;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: update the model at the edge, compare away from it
  task automatic step(input string btag, input string ptag);
    logic dec;
    @(posedge clk);
    if (!bat_rst_n) m_prev = 1'b0;
    dec = want_on(policy, m_prev);
    if (!rst_n) begin
      m_armed = 1'b1;
      m_left  = 0;
    end else if (m_armed) begin
      m_armed = 1'b0;
      m_left  = dec ? NT : 0;
    end else if (m_left > 0 && tick) begin
      m_left--;
    end
    if (bat_rst_n && rst_n && tick && !pwr_fail) m_prev = ~slp_req;
    @(negedge clk);
    chk(btag, btn_out_n, exp_btn());
    chk("R1", supply_on, ~slp_req);
    chk(ptag, prev_on, m_prev);
  endtask

  task automatic quiet();
    btn_in_n = 1'b1; kbd_req_n = 1'b1;
    btn_en = 1'b1; kbd_en = 1'b1;
  endtask

  // run the board with a fixed supply level so prev_on settles
  task automatic settle(input logic on);
    slp_req = ~on;
    pwr_fail = 1'b0;
    tick = 1'b1;
    step("R2", "R8");
    tick = 1'b0;
  endtask

  // AC loss and return with a given policy, ticks at random
  task automatic power_cycle(input logic [1:0] pol, input string tag);
    pwr_fail = 1'b1;
    for (int i = 0; i < 3; i++) begin tick = $urandom_range(0, 1); step(tag, "R8"); end
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin tick = $urandom_range(0, 1); step("R10", "R9"); end
    policy = pol;
    rst_n = 1'b1;
    step(tag, "R8");
    pwr_fail = 1'b0;
    for (int i = 0; i < 4 * NT + 6; i++) begin
      tick = $urandom_range(0, 1);
      step(tag, "R8");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; bat_rst_n = 1'b0; tick = 1'b0; pwr_fail = 1'b0;
    slp_req = 1'b1; policy = 2'b00;
    quiet();
    m_prev = 1'b0; m_armed = 1'b1; m_left = 0;

    // R10: reset state
    step("R10", "R9");
    bat_rst_n = 1'b1;
    step("R10", "R9");
    chk("R10", btn_out_n, 1'b1);
    chk("R9", prev_on, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R5", "R8");

    // R8: sampling and freezing
    settle(1'b1);
    chk("R8", prev_on, 1'b1);
    pwr_fail = 1'b1; slp_req = 1'b1; tick = 1'b1;
    step("R2", "R8"); step("R2", "R8");
    chk("R8", prev_on, 1'b1);
    pwr_fail = 1'b0; tick = 1'b0;

    // R5: stay-off with saved on
    power_cycle(2'b00, "R5");
    // R5: turn-on with saved off
    settle(1'b0);
    power_cycle(2'b11, "R5");
    // R6: restore encodings
    settle(1'b1); power_cycle(2'b01, "R6");
    settle(1'b1); power_cycle(2'b10, "R6");
    settle(1'b0); power_cycle(2'b01, "R6");
    settle(1'b0); power_cycle(2'b10, "R6");

    // R4: exact length with a tick every cycle
    settle(1'b0);
    pwr_fail = 1'b1; rst_n = 1'b0; step("R10", "R9");
    policy = 2'b11; rst_n = 1'b1; tick = 1'b1;
    step("R4", "R8");
    chk("R4", btn_out_n, 1'b0);
    for (int i = 0; i < NT - 1; i++) step("R4", "R8");
    chk("R4", btn_out_n, 1'b0);
    step("R4", "R8");
    chk("R4", btn_out_n, 1'b1);
    // R7: no second pulse
    for (int i = 0; i < 3 * NT; i++) step("R7", "R8");
    chk("R7", btn_out_n, 1'b1);
    tick = 1'b0; pwr_fail = 1'b0;

    // R9: standby reset keeps the saved bit, battery reset clears it
    settle(1'b1);
    rst_n = 1'b0; step("R10", "R9"); step("R10", "R9");
    chk("R9", prev_on, 1'b1);
    rst_n = 1'b1; policy = 2'b00; step("R5", "R8");
    bat_rst_n = 1'b0; step("R2", "R9");
    chk("R9", prev_on, 1'b0);
    bat_rst_n = 1'b1;

    // R2 / R3: live paths, enabled and disabled
    btn_in_n = 1'b0; btn_en = 1'b1; kbd_req_n = 1'b1;
    step("R2", "R8"); chk("R2", btn_out_n, 1'b0);
    btn_en = 1'b0; step("R2", "R8"); chk("R2", btn_out_n, 1'b1);
    btn_in_n = 1'b1; kbd_req_n = 1'b0; kbd_en = 1'b1;
    step("R3", "R8"); chk("R3", btn_out_n, 1'b0);
    kbd_en = 1'b0; step("R3", "R8"); chk("R3", btn_out_n, 1'b1);
    quiet();

    // random mix of live requests, sleep levels, ticks and power cycles
    for (int k = 0; k < 30; k++) begin
      for (int i = 0; i < 40; i++) begin
        btn_in_n = $urandom_range(0, 3) != 0;
        kbd_req_n = $urandom_range(0, 3) != 0;
        btn_en = $urandom_range(0, 1);
        kbd_en = $urandom_range(0, 1);
        slp_req = $urandom_range(0, 1);
        tick = $urandom_range(0, 1);
        step("R3", "R8");
      end
      quiet();
      power_cycle(2'($urandom_range(0, 3)), "R6");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule